// File: doc/BRIEF.md
# Filtered Instruction Prefetcher with Stream Buffer

This block sits beside an instruction cache and keeps useful lines close at hand while the front end is stalled. When the cache is stuck on a demand miss, the decoupled fetch queue still produces look-ahead line addresses. The block takes those addresses and asks the cache tag array whether each line is already resident. A line that is resident, already held in the stream buffer, already waiting in the queue, or already requested from memory is discarded. Every other candidate is placed in a short FIFO of prefetch addresses.

The block sends one prefetch request to memory at a time, and only while the cache is not handling a demand miss. A demand miss therefore always has the memory port to itself. A returning line is written into a small fully associative stream buffer, not into the cache, so a wrong guess never evicts a useful cache line. Every demand fetch looks up the stream buffer in the same cycle as the cache. On a hit, the buffer returns the line for the fetch path and for promotion into the cache, and the buffer entry is freed. A flush empties the address FIFO and cancels any request still in flight, so the line that request returns is dropped.

The candidate and memory-request interfaces are valid/ready. A candidate transfers when `cand_valid` and `cand_ready` are both high on a clock edge. The block raises `cand_ready` only during a miss stall, outside a flush and while the FIFO has room. A memory request transfers when `mem_req_valid` and `mem_req_ready` are both high. While a request waits unaccepted, `mem_req_addr` holds steady. `mem_req_valid` may drop before acceptance when a demand miss or a flush starts, and this is how demand traffic takes the port. Memory responses carry no ready signal, and the block accepts one in any cycle. The tag probe and the demand lookup are both combinational and answer in the same cycle.

Top module: `ifetch_prefetcher`

## Requirements
- R1: After reset, `mem_req_valid` is low, the address FIFO is empty and no stream-buffer entry is valid, so `dem_hit` is low for every address.
- R2: `cand_ready` is high only when `miss_stall` is high, `flush` is low and the address FIFO holds fewer than QDEPTH (default 4) entries.
- R3: `tag_probe_addr` equals `cand_addr`. A candidate accepted while `tag_probe_hit` is high is discarded and never requested from memory.
- R4: An accepted candidate is also discarded, and never requested a second time, when its address matches a valid stream-buffer entry, an address waiting in the FIFO, or the single outstanding request that has not been cancelled.
- R5: Surviving candidates are requested from memory in the order they were accepted.
- R6: `mem_req_valid` is low while `miss_stall` is high and while a request is outstanding. While a request waits unaccepted, `mem_req_addr` holds steady.
- R7: A response to an outstanding request that has not been cancelled writes the line (`mem_rsp_line`) into the stream buffer. From the next cycle on, a demand lookup of that address has `dem_hit` high and `dem_line` equal to the returned line in the same cycle.
- R8: A demand hit frees the entry, so a lookup of the same address in the following cycle misses, unless a new line for that address was written in the cycle of the hit.
- R9: The stream buffer has SB_ENTRIES (default 4) entries, replaced first-in first-out. The fifth line written overwrites the first line written, even if that line is still valid.
- R10: A flush empties the address FIFO and cancels the outstanding request. No FIFO entry present at the flush is ever requested, and the response to the cancelled request is not stored.
- R11: `dem_hit` is low whenever `dem_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clears the address FIFO and cancels the in-flight request |
| miss_stall | input | 1 | High while the cache services a demand miss |
| cand_valid | input | 1 | Look-ahead candidate offered |
| cand_ready | output | 1 | Candidate accepted this cycle |
| cand_addr | input | AW | Candidate line address |
| tag_probe_addr | output | AW | Line address sent to the cache tag probe |
| tag_probe_hit | input | 1 | Cache tag probe result for `tag_probe_addr` |
| mem_req_valid | output | 1 | Prefetch request offered to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Prefetch request line address |
| mem_rsp_valid | input | 1 | Response line valid for the outstanding request |
| mem_rsp_line | input | LW | Response line data |
| dem_valid | input | 1 | Demand fetch lookup strobe |
| dem_addr | input | AW | Demand fetch line address |
| dem_hit | output | 1 | Stream buffer holds the demanded line |
| dem_line | output | LW | Line returned to fetch and for promotion into the cache |

## Verification
A sweep of eight consecutive candidates mixes tag hits and tag misses and runs past the FIFO depth. The tag hits must be dropped, the survivors must come out in order, and the sweep also shows where back-pressure starts. Repeated addresses are offered while the same line sits in the stream buffer, in the FIFO and as the outstanding request, which exercises each duplicate filter separately. A fifth fill, followed by lookups of the oldest and newest lines, separates FIFO replacement from lookup by age. Flushes are applied once with addresses still queued and once with a request in flight. These two cases separate clearing the FIFO from discarding the response, and a later fill shows that prefetching recovers afterwards.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned PF_AW_DEF  = 16;
  localparam int unsigned PF_LW_DEF  = 32;
  localparam int unsigned PF_QD_DEF  = 4;
  localparam int unsigned PF_SB_DEF  = 4;
endpackage

// File: rtl/pf_addr_queue.sv
module pf_addr_queue #(
  parameter int unsigned AW    = pf_pkg::PF_AW_DEF,
  parameter int unsigned DEPTH = pf_pkg::PF_QD_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic          empty,
  output logic          full,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_match
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic [DEPTH-1:0] match_vec;

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign head_addr = mem_q[rd_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    logic [PW-1:0] off;
    assign off = PW'(i) - rd_q;
    assign match_vec[i] = (CW'(off) < cnt_q) && (mem_q[i] == probe_addr);
  end
  assign probe_match = |match_vec;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push && !full) begin
        mem_q[wr_q] <= push_addr;
        wr_q        <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
      if (pop && !empty) begin
        rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
      cnt_q <= cnt_q + CW'(push && !full) - CW'(pop && !empty);
    end
  end
endmodule

// File: rtl/pf_stream_buf.sv
module pf_stream_buf #(
  parameter int unsigned AW      = pf_pkg::PF_AW_DEF,
  parameter int unsigned LW      = pf_pkg::PF_LW_DEF,
  parameter int unsigned ENTRIES = pf_pkg::PF_SB_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          look_valid,
  input  logic [AW-1:0] look_addr,
  output logic          look_hit,
  output logic [LW-1:0] look_line,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_addr,
  input  logic [LW-1:0] fill_line
);
  localparam int unsigned EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [AW-1:0]      tag_q  [ENTRIES];
  logic [LW-1:0]      line_q [ENTRIES];
  logic [EW-1:0]      wptr_q;
  logic [ENTRIES-1:0] look_vec, probe_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign look_vec[i]  = vld_q[i] && (tag_q[i] == look_addr);
    assign probe_vec[i] = vld_q[i] && (tag_q[i] == probe_addr);
  end

  assign look_hit  = look_valid && (|look_vec);
  assign probe_hit = |probe_vec;

  always_comb begin
    look_line = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_vec[i]) look_line = line_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      wptr_q <= '0;
    end else begin
      if (look_hit) vld_q <= vld_q & ~look_vec;
      if (fill_valid) begin
        vld_q[wptr_q]  <= 1'b1;
        tag_q[wptr_q]  <= fill_addr;
        line_q[wptr_q] <= fill_line;
        wptr_q <= (wptr_q == EW'(ENTRIES - 1)) ? '0 : wptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ifetch_prefetcher.sv
module ifetch_prefetcher #(
  parameter int unsigned AW         = pf_pkg::PF_AW_DEF,
  parameter int unsigned LW         = pf_pkg::PF_LW_DEF,
  parameter int unsigned QDEPTH     = pf_pkg::PF_QD_DEF,
  parameter int unsigned SB_ENTRIES = pf_pkg::PF_SB_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          miss_stall,
  input  logic          cand_valid,
  output logic          cand_ready,
  input  logic [AW-1:0] cand_addr,
  output logic [AW-1:0] tag_probe_addr,
  input  logic          tag_probe_hit,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [LW-1:0] mem_rsp_line,
  input  logic          dem_valid,
  input  logic [AW-1:0] dem_addr,
  output logic          dem_hit,
  output logic [LW-1:0] dem_line
);
  logic          q_empty, q_full, q_match, q_push, q_pop;
  logic [AW-1:0] q_head;
  logic          sb_probe_hit;
  logic          out_valid, out_cancel;
  logic [AW-1:0] out_addr;
  logic          cand_fire, cand_dup, req_fire, fill_valid;

  assign tag_probe_addr = cand_addr;
  assign cand_ready     = miss_stall && !flush && !q_full;
  assign cand_fire      = cand_valid && cand_ready;
  assign cand_dup       = tag_probe_hit || sb_probe_hit || q_match ||
                          (out_valid && !out_cancel && (out_addr == cand_addr));
  assign q_push         = cand_fire && !cand_dup;

  assign mem_req_valid  = !miss_stall && !flush && !q_empty && !out_valid;
  assign mem_req_addr   = q_head;
  assign req_fire       = mem_req_valid && mem_req_ready;
  assign q_pop          = req_fire;

  assign fill_valid     = mem_rsp_valid && out_valid && !out_cancel && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_cancel <= 1'b0;
      out_addr   <= '0;
    end else if (req_fire) begin
      out_valid  <= 1'b1;
      out_cancel <= 1'b0;
      out_addr   <= q_head;
    end else if (mem_rsp_valid && out_valid) begin
      out_valid  <= 1'b0;
      out_cancel <= 1'b0;
    end else if (flush && out_valid) begin
      out_cancel <= 1'b1;
    end
  end

  pf_addr_queue #(.AW(AW), .DEPTH(QDEPTH)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (flush),
    .push        (q_push),
    .push_addr   (cand_addr),
    .pop         (q_pop),
    .head_addr   (q_head),
    .empty       (q_empty),
    .full        (q_full),
    .probe_addr  (cand_addr),
    .probe_match (q_match)
  );

  pf_stream_buf #(.AW(AW), .LW(LW), .ENTRIES(SB_ENTRIES)) u_sbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_valid (dem_valid),
    .look_addr  (dem_addr),
    .look_hit   (dem_hit),
    .look_line  (dem_line),
    .probe_addr (cand_addr),
    .probe_hit  (sb_probe_hit),
    .fill_valid (fill_valid),
    .fill_addr  (out_addr),
    .fill_line  (mem_rsp_line)
  );
endmodule

// File: rtl/ifetch_prefetcher_chk.sv
module ifetch_prefetcher_chk #(
  parameter int unsigned AW = pf_pkg::PF_AW_DEF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          miss_stall,
  input logic          cand_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          dem_valid,
  input logic [AW-1:0] dem_addr,
  input logic          dem_hit,
  input logic          out_valid,
  input logic          fill_valid
);
  p_ready_in_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cand_ready |-> (miss_stall && !flush));

  p_no_req_in_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_stall |-> !mem_req_valid);

  p_single_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_req_valid);

  p_req_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (!mem_req_valid || $stable(mem_req_addr)));

  p_hit_invalidates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_valid && dem_hit && !fill_valid) |=>
      !(dem_valid && dem_hit && (dem_addr == $past(dem_addr))));

  p_flush_drains_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !mem_req_valid);

  p_hit_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dem_valid |-> !dem_hit);
endmodule

bind ifetch_prefetcher ifetch_prefetcher_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .miss_stall    (miss_stall),
  .cand_ready    (cand_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .dem_valid     (dem_valid),
  .dem_addr      (dem_addr),
  .dem_hit       (dem_hit),
  .out_valid     (out_valid),
  .fill_valid    (fill_valid)
);

// File: tb/ifetch_prefetcher_test.sv
module ifetch_prefetcher_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 32;
  localparam int QD = 4;

  logic          clk = 1'b0;
  logic          rst_n, flush, miss_stall;
  logic          cand_valid, cand_ready, tag_probe_hit;
  logic [AW-1:0] cand_addr, tag_probe_addr;
  logic          mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [LW-1:0] mem_rsp_line;
  logic          dem_valid, dem_hit;
  logic [AW-1:0] dem_addr;
  logic [LW-1:0] dem_line;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_prefetcher #(.AW(AW), .LW(LW), .QDEPTH(QD), .SB_ENTRIES(4)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .miss_stall(miss_stall),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr),
    .tag_probe_addr(tag_probe_addr), .tag_probe_hit(tag_probe_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_line(mem_rsp_line), .dem_valid(dem_valid), .dem_addr(dem_addr),
    .dem_hit(dem_hit), .dem_line(dem_line)
  );

  function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
    return {a, a ^ 16'h5A5A};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic offer(input logic [AW-1:0] a, input logic ph, input logic exp_rdy,
                       input string req);
    cand_valid = 1'b1; cand_addr = a; tag_probe_hit = ph;
    #1;
    chk(req, {63'd0, cand_ready}, {63'd0, exp_rdy});
    step();
    cand_valid = 1'b0; tag_probe_hit = 1'b0;
  endtask

  task automatic issue_expect(input logic [AW-1:0] a, input string req);
    #1;
    chk(req, {63'd0, mem_req_valid}, 64'd1);
    chk(req, {48'd0, mem_req_addr}, {48'd0, a});
    mem_req_ready = 1'b1;
    step();
    mem_req_ready = 1'b0;
    #1;
    chk("R6 outstanding blocks request", {63'd0, mem_req_valid}, 64'd0);
  endtask

  task automatic respond(input logic [AW-1:0] a);
    mem_rsp_valid = 1'b1; mem_rsp_line = line_of(a);
    step();
    mem_rsp_valid = 1'b0;
  endtask

  task automatic lookup(input logic [AW-1:0] a, input logic exp_hit, input string req);
    dem_valid = 1'b1; dem_addr = a;
    #1;
    chk(req, {63'd0, dem_hit}, {63'd0, exp_hit});
    if (exp_hit) chk(req, {32'd0, dem_line}, {32'd0, line_of(a)});
    step();
    dem_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int queued;
    rst_n = 1'b0; flush = 1'b0; miss_stall = 1'b0;
    cand_valid = 1'b0; cand_addr = '0; tag_probe_hit = 1'b0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_line = '0;
    dem_valid = 1'b0; dem_addr = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 no request after reset", {63'd0, mem_req_valid}, 64'd0);
    chk("R2 not ready outside stall", {63'd0, cand_ready}, 64'd0);
    lookup(16'h0000, 1'b0, "R1 empty stream buffer");

    // R3/R5/R2 sweep: tag hits on i%3==0, queue fills after 4 survivors
    miss_stall = 1'b1;
    queued = 0;
    for (int i = 0; i < 8; i++) begin
      logic ph;
      ph = ((i % 3) == 0);
      cand_addr = 16'h0100 + 16'(i);
      #1;
      chk("R3 probe address follows candidate", {48'd0, tag_probe_addr}, {48'd0, cand_addr});
      chk("R6 no request during stall", {63'd0, mem_req_valid}, 64'd0);
      offer(16'h0100 + 16'(i), ph, (queued < QD), "R2 ready tracks FIFO room");
      if (queued < QD && !ph) queued++;
    end

    miss_stall = 1'b0;
    #1;
    chk("R6 request after stall ends", {63'd0, mem_req_valid}, 64'd1);
    chk("R5 first survivor", {48'd0, mem_req_addr}, 64'h0101);
    step();
    chk("R6 address held while unaccepted", {48'd0, mem_req_addr}, 64'h0101);
    issue_expect(16'h0101, "R5 order 0"); respond(16'h0101);
    issue_expect(16'h0102, "R5 order 1"); respond(16'h0102);
    issue_expect(16'h0104, "R5 order 2"); respond(16'h0104);
    issue_expect(16'h0105, "R5 order 3"); respond(16'h0105);
    #1;
    chk("R3 tag hits never requested", {63'd0, mem_req_valid}, 64'd0);
    lookup(16'h0100, 1'b0, "R3 dropped line absent");

    // R9 fifth fill evicts the oldest
    miss_stall = 1'b1;
    offer(16'h0200, 1'b0, 1'b1, "R2 ready");
    miss_stall = 1'b0;
    issue_expect(16'h0200, "R5 single"); respond(16'h0200);
    lookup(16'h0101, 1'b0, "R9 oldest evicted");
    lookup(16'h0200, 1'b1, "R7 newest present");
    lookup(16'h0105, 1'b1, "R7 line data");

    // R8 hit frees entry
    lookup(16'h0102, 1'b1, "R8 first hit");
    lookup(16'h0102, 1'b0, "R8 miss after hit");

    // R11 lookup strobe gating (0x104 still present)
    dem_valid = 1'b0; dem_addr = 16'h0104;
    #1;
    chk("R11 no hit without strobe", {63'd0, dem_hit}, 64'd0);
    step();

    // R4 duplicate filters
    miss_stall = 1'b1;
    offer(16'h0104, 1'b0, 1'b1, "R4 sb duplicate offered");
    offer(16'h0300, 1'b0, 1'b1, "R4 new line offered");
    offer(16'h0300, 1'b0, 1'b1, "R4 queued duplicate offered");
    miss_stall = 1'b0;
    issue_expect(16'h0300, "R4 sb duplicate skipped");
    miss_stall = 1'b1;
    offer(16'h0300, 1'b0, 1'b1, "R4 outstanding duplicate offered");
    miss_stall = 1'b0;
    respond(16'h0300);
    #1;
    chk("R4 no duplicate requests", {63'd0, mem_req_valid}, 64'd0);
    lookup(16'h0104, 1'b1, "R4 sb line kept");

    // R10 flush with queued addresses
    miss_stall = 1'b1;
    offer(16'h0400, 1'b0, 1'b1, "R2 ready");
    offer(16'h0401, 1'b0, 1'b1, "R2 ready");
    flush = 1'b1;
    #1;
    chk("R2 not ready during flush", {63'd0, cand_ready}, 64'd0);
    step();
    flush = 1'b0;
    miss_stall = 1'b0;
    #1;
    chk("R10 queue emptied", {63'd0, mem_req_valid}, 64'd0);
    step();

    // R10 flush with request in flight
    miss_stall = 1'b1;
    offer(16'h0500, 1'b0, 1'b1, "R2 ready");
    miss_stall = 1'b0;
    issue_expect(16'h0500, "R10 issue before flush");
    flush = 1'b1;
    step();
    flush = 1'b0;
    respond(16'h0500);
    lookup(16'h0500, 1'b0, "R10 cancelled response dropped");

    miss_stall = 1'b1;
    offer(16'h0600, 1'b0, 1'b1, "R2 ready");
    miss_stall = 1'b0;
    issue_expect(16'h0600, "R10 recovery issue"); respond(16'h0600);
    lookup(16'h0600, 1'b1, "R7 fill after recovery");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule